// File: doc/BRIEF.md
# Single-Wire Debug Host Bit Engine

This block is the host end of a one-wire, open-drain debug link. It takes one bit command at a time: send a zero, send a one, or read a bit. Each command becomes a fixed bit window on the wire. The host clock is assumed to run at the same rate as the target clock. Every window starts with the host pulling the line low so that the target sees a falling edge.

For a one or a read, the low drive is short and then the line floats. It must float well before the target may drive its brief high speed-up pulse in cycle 7 of the bit. For a zero, the low drive is held past the point where the target senses the level. On a read, the wire level is captured at a fixed offset inside the window and returned with a one-cycle valid pulse once the window closes. The wire is modelled as a low-drive enable plus a sensed input. The host never drives the line high.

Byte framing and the debug command protocol sit above this block. They feed it one bit command per window.

Top module: `dbg_host_bit_engine`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), and after it, the low-drive enable dq_oe is 0, rd_valid is 0 and cmd_ready is 1.
- R2: A command is accepted on a clock edge where cmd_valid and cmd_ready are both 1. The cycle that follows that edge is cycle 0 of the bit window. dq_oe is 1 in cycles 0 and 1 of every bit window.
- R3: For cmd_op 2'b01 (send one) and for a read, dq_oe is 1 in cycles 0 to 3 exactly and 0 in cycles 4 to 15.
- R4: For cmd_op 2'b00 (send zero), dq_oe is 1 in cycles 0 to 12 and 0 in cycles 13 to 15.
- R5: During a read, dq_oe is 0 from cycle 7 of the window to its end, so the target's speed-up pulse never meets a low drive.
- R6: A bit window lasts 16 cycles. cmd_ready is 0 in cycles 0 to 14 and 1 in cycle 15. A command accepted at the end of cycle 15 starts its cycle 0 in the next cycle, and dq_oe is 0 whenever no window is running.
- R7: A read returns the level of dq_in during cycle 10 of its window. The level of dq_in in any other cycle has no effect on the result.
- R8: rd_valid is 1 for exactly one cycle, the cycle after cycle 15 of a read window, with rd_data holding the captured level. Send windows never raise rd_valid.
- R9: cmd_op 2'b10 and 2'b11 both encode a read, and both behave identically.
- R10: cmd_valid and cmd_op presented while cmd_ready is 0 are ignored. The drive pattern and the window length of the running bit are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock, same rate as the target clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A bit command is offered |
| cmd_op | input | 2 | 00 send zero, 01 send one, 1x read |
| cmd_ready | output | 1 | Engine can accept a command on this edge |
| dq_oe | output | 1 | 1 pulls the wire low, 0 leaves it high impedance |
| dq_in | input | 1 | Sensed level of the wire |
| rd_valid | output | 1 | One-cycle pulse carrying a read result |
| rd_data | output | 1 | Read result, valid with rd_valid |

## Verification
A wrong window counter shows up at once as a low pulse of the wrong length on dq_oe, or as cmd_ready rising in a cycle other than 15. Either one is visible within a single bit. A stale or swapped command register makes the drive pattern of the next window wrong from its fifth cycle on. A capture taken at the wrong offset only shows once a target pattern differs between cycle 10 and its neighbours. The read-back then returns the wrong value 6 cycles later, when rd_valid fires. Because of this, target patterns are randomised around the sample point.

// File: rtl/dbghb_pkg.sv
package dbghb_pkg;

   typedef enum logic [1:0] {
      OP_SEND0    = 2'b00,
      OP_SEND1    = 2'b01,
      OP_READ     = 2'b10,
      OP_READ_ALT = 2'b11
   } bit_op_e;

   // upper bit of the opcode marks a read
   function automatic logic op_reads(input bit_op_e op);
      return op[1];
   endfunction

endpackage

// File: rtl/dbghb_window.sv
module dbghb_window #(
   parameter int WINDOW = 16,
   parameter int CW     = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          busy,
   output logic [CW-1:0] pos,
   output logic          last,
   output logic          ready
);
   localparam logic [CW-1:0] LAST_POS = CW'(WINDOW - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         pos  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         pos  <= '0;
      end else if (last) begin
         busy <= 1'b0;
         pos  <= '0;
      end else if (busy) begin
         pos  <= pos + 1'b1;
      end
   end

   assign last  = busy && (pos == LAST_POS);
   // the final cycle of a window may hand over to the next bit
   assign ready = !busy || last;
endmodule

// File: rtl/dbghb_drive.sv
module dbghb_drive
   import dbghb_pkg::*;
#(
   parameter int CW        = 4,
   parameter int SHORT_LOW = 4,
   parameter int LONG_LOW  = 13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [1:0]    op_in,
   input  logic          busy,
   input  logic [CW-1:0] pos,
   output logic          dq_oe,
   output logic          is_read
);
   localparam logic [CW-1:0] SHORT_LIM = CW'(SHORT_LOW);
   localparam logic [CW-1:0] LONG_LIM  = CW'(LONG_LOW);

   bit_op_e       op_q;
   logic [CW-1:0] low_lim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     op_q <= OP_SEND1;
      else if (start) op_q <= bit_op_e'(op_in);
   end

   // only a zero keeps the wire low past the target's sense point
   assign low_lim = (op_q == OP_SEND0) ? LONG_LIM : SHORT_LIM;
   assign dq_oe   = busy && (pos < low_lim);
   assign is_read = op_reads(op_q);
endmodule

// File: rtl/dbghb_sampler.sv
module dbghb_sampler #(
   parameter int CW          = 4,
   parameter int SYNC_STAGES = 0,
   parameter int CAPTURE_AT  = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dq_in,
   input  logic          busy,
   input  logic [CW-1:0] pos,
   input  logic          last,
   input  logic          is_read,
   output logic          rd_valid,
   output logic          rd_data
);
   localparam logic [CW-1:0] CAP_POS = CW'(CAPTURE_AT);

   logic dq_s;
   logic smp_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign dq_s = dq_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh[0] <= 1'b1;
            else        sh[0] <= dq_in;
         end
         for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sh[g] <= 1'b1;
               else        sh[g] <= sh[g-1];
            end
         end
         assign dq_s = sh[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_q    <= 1'b1;
         rd_valid <= 1'b0;
         rd_data  <= 1'b0;
      end else begin
         if (busy && (pos == CAP_POS)) smp_q <= dq_s;
         rd_valid <= last && is_read;
         if (last && is_read) rd_data <= smp_q;
      end
   end
endmodule

// File: rtl/dbg_host_bit_engine.sv
module dbg_host_bit_engine
   import dbghb_pkg::*;
#(
   parameter int WINDOW      = 16,
   parameter int MIN_LOW     = 2,
   parameter int SHORT_LOW   = 4,
   parameter int LONG_LOW    = 13,
   parameter int SPEEDUP_AT  = 7,
   parameter int SAMPLE_AT   = 10,
   parameter int SYNC_STAGES = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [1:0] cmd_op,
   output logic       cmd_ready,
   output logic       dq_oe,
   input  logic       dq_in,
   output logic       rd_valid,
   output logic       rd_data
);
   localparam int CW         = (WINDOW > 2) ? $clog2(WINDOW) : 1;
   // a synchroniser delays the sensed level, so capture later by as much
   localparam int CAPTURE_AT = SAMPLE_AT + SYNC_STAGES;

   generate
      if (SHORT_LOW < MIN_LOW) begin : g_err_short
         $error("short low drive too brief for the target to detect");
      end
      if (SHORT_LOW > SPEEDUP_AT) begin : g_err_speedup
         $error("short low drive overlaps the speed-up pulse");
      end
      if (LONG_LOW <= SAMPLE_AT || LONG_LOW >= WINDOW) begin : g_err_long
         $error("long low drive must cover the sample point and end inside the window");
      end
      if (SAMPLE_AT < SPEEDUP_AT || CAPTURE_AT > WINDOW - 2) begin : g_err_sample
         $error("capture point out of range");
      end
      if (SYNC_STAGES < 0) begin : g_err_sync
         $error("negative synchroniser depth");
      end
   endgenerate

   logic          start, busy, last, is_read;
   logic [CW-1:0] pos;

   assign start = cmd_valid && cmd_ready;

   dbghb_window #(.WINDOW(WINDOW), .CW(CW)) u_window (
      .clk(clk), .rst_n(rst_n), .start(start),
      .busy(busy), .pos(pos), .last(last), .ready(cmd_ready)
   );

   dbghb_drive #(.CW(CW), .SHORT_LOW(SHORT_LOW), .LONG_LOW(LONG_LOW)) u_drive (
      .clk(clk), .rst_n(rst_n), .start(start), .op_in(cmd_op),
      .busy(busy), .pos(pos), .dq_oe(dq_oe), .is_read(is_read)
   );

   dbghb_sampler #(.CW(CW), .SYNC_STAGES(SYNC_STAGES), .CAPTURE_AT(CAPTURE_AT)) u_sampler (
      .clk(clk), .rst_n(rst_n), .dq_in(dq_in), .busy(busy), .pos(pos),
      .last(last), .is_read(is_read), .rd_valid(rd_valid), .rd_data(rd_data)
   );
endmodule

// File: rtl/dbghb_checker.sv
module dbghb_checker #(
   parameter int WINDOW     = 16,
   parameter int MIN_LOW    = 2,
   parameter int SHORT_LOW  = 4,
   parameter int LONG_LOW   = 13,
   parameter int SPEEDUP_AT = 7
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic [1:0] cmd_op,
   input logic       cmd_ready,
   input logic       dq_oe,
   input logic       rd_valid
);
   localparam int CW = (WINDOW > 2) ? $clog2(WINDOW) : 1;
   localparam logic [CW-1:0] P_LAST  = CW'(WINDOW - 1);
   localparam logic [CW-1:0] P_MIN   = CW'(MIN_LOW);
   localparam logic [CW-1:0] P_SHORT = CW'(SHORT_LOW);
   localparam logic [CW-1:0] P_LONG  = CW'(LONG_LOW);
   localparam logic [CW-1:0] P_SPEED = CW'(SPEEDUP_AT);

   logic          ck_busy;
   logic [CW-1:0] ck_pos;
   logic [1:0]    ck_op;
   logic          acc;

   assign acc = cmd_valid && cmd_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_busy <= 1'b0;
         ck_pos  <= '0;
         ck_op   <= 2'b00;
      end else if (acc) begin
         ck_busy <= 1'b1;
         ck_pos  <= '0;
         ck_op   <= cmd_op;
      end else if (ck_busy && ck_pos == P_LAST) begin
         ck_busy <= 1'b0;
      end else if (ck_busy) begin
         ck_pos  <= ck_pos + 1'b1;
      end
   end

   // R2
   start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ck_busy && ck_pos < P_MIN |-> dq_oe);
   // R3
   short_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ck_busy && ck_op != 2'b00 && ck_pos >= P_SHORT |-> !dq_oe);
   // R4
   long_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ck_busy && ck_op == 2'b00 |-> (dq_oe == (ck_pos < P_LONG)));
   // R5
   speedup_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ck_busy && ck_op[1] && ck_pos >= P_SPEED |-> !dq_oe);
   // R6
   window_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ck_busy |-> (cmd_ready == (ck_pos == P_LAST)));
   // R6
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ck_busy |-> !dq_oe && cmd_ready);
   // R8
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);
   // R8
   valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(ck_busy && ck_pos == P_LAST && ck_op[1]));
endmodule

bind dbg_host_bit_engine dbghb_checker #(
   .WINDOW(WINDOW), .MIN_LOW(MIN_LOW), .SHORT_LOW(SHORT_LOW),
   .LONG_LOW(LONG_LOW), .SPEEDUP_AT(SPEEDUP_AT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
   .cmd_ready(cmd_ready), .dq_oe(dq_oe), .rd_valid(rd_valid)
);

// File: tb/dbg_host_bit_engine_tb.sv
`timescale 1ns/1ps
module dbg_host_bit_engine_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [1:0] cmd_op = 2'b00;
   logic       cmd_ready, dq_oe, rd_valid, rd_data;
   logic       tgt_low = 1'b0;
   logic       dq_line;

   int     checks = 0;
   int     errors = 0;
   bit     done = 1'b0;
   longint cyc = 0;
   bit     pend_valid = 1'b0;
   bit     pend_data = 1'b0;
   string  pend_tag = "R7";

   // open-drain wire with pull-up: host or target may pull low
   assign dq_line = !(dq_oe || tgt_low);

   always #2 clk = ~clk;

   dbg_host_bit_engine u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_ready(cmd_ready), .dq_oe(dq_oe), .dq_in(dq_line),
      .rd_valid(rd_valid), .rd_data(rd_data)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit exp_low(input logic [1:0] op, input int k);
      return (op == 2'b00) ? (k < 13) : (k < 4);
   endfunction

   function automatic string low_tag(input logic [1:0] op, input int k);
      if (k < 2)                 return "R2";
      if (op == 2'b00)           return "R4";
      if (op[1] && k >= 7)       return "R5";
      return "R3";
   endfunction

   task automatic check_result();
      chk(rd_valid == pend_valid, "R8", rd_valid, pend_valid);
      if (pend_valid) chk(rd_data == pend_data, pend_tag, rd_data, pend_data);
      pend_valid = 1'b0;
   endtask

   // call at a negedge where cmd_ready is 1; returns at the negedge of cycle 15
   task automatic run_bit(input logic [1:0] op, input logic [15:0] tpat,
                          input bit noise, input bit tbit);
      cmd_valid = 1'b1;
      cmd_op    = op;
      for (int k = 0; k < 16; k++) begin
         @(posedge clk); @(negedge clk);
         tgt_low = tpat[k];
         chk(dq_oe == exp_low(op, k), noise ? "R10" : low_tag(op, k), dq_oe, exp_low(op, k));
         chk(cmd_ready == (k == 15), noise ? "R10" : "R6", cmd_ready, (k == 15));
         check_result();
         if (k < 15 && noise) begin
            cmd_valid = 1'($urandom_range(1, 0));
            cmd_op    = 2'($urandom_range(3, 0));
         end else begin
            cmd_valid = 1'b0;
         end
      end
      tgt_low    = 1'b0;
      pend_valid = op[1];
      pend_data  = tbit;
      pend_tag   = (op == 2'b11) ? "R9" : "R7";
   endtask

   task automatic idle(input int n);
      cmd_valid = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(posedge clk); @(negedge clk);
         chk(dq_oe == 1'b0, "R6", dq_oe, 0);
         chk(cmd_ready == 1'b1, "R6", cmd_ready, 1);
         check_result();
      end
   endtask

   task automatic rand_read(input logic [1:0] op, input bit noise);
      bit          b;
      logic [15:0] p;
      b    = 1'($urandom_range(1, 0));
      p    = 16'($urandom());
      p[10] = !b;
      run_bit(op, p, noise, b);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=0", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(dq_oe == 1'b0, "R1", dq_oe, 0);
      chk(rd_valid == 1'b0, "R1", rd_valid, 0);
      chk(cmd_ready == 1'b1, "R1", cmd_ready, 1);
      rst_n = 1'b1;
      idle(3);

      // directed: each opcode, clean target
      run_bit(2'b00, 16'h0000, 1'b0, 1'b0);
      run_bit(2'b01, 16'h0000, 1'b0, 1'b0);
      run_bit(2'b10, 16'h0000, 1'b0, 1'b1);
      run_bit(2'b10, 16'h1FF0, 1'b0, 1'b0);
      // R9: alternate read code
      run_bit(2'b11, 16'h1FF0, 1'b0, 1'b0);
      run_bit(2'b11, 16'h0000, 1'b0, 1'b1);
      idle(2);
      // R7: only cycle 10 matters
      run_bit(2'b10, 16'hFBFF, 1'b0, 1'b1);
      run_bit(2'b10, 16'h0400, 1'b0, 1'b0);
      run_bit(2'b10, 16'hF9FF, 1'b0, 1'b1);
      // R10: garbage while busy
      run_bit(2'b00, 16'h0000, 1'b1, 1'b0);
      run_bit(2'b10, 16'hFBFF, 1'b1, 1'b1);
      idle(1);

      // random mix of back-to-back bits and gaps
      for (int n = 0; n < 300; n++) begin
         logic [1:0] op;
         bit         noise;
         op    = 2'($urandom_range(3, 0));
         noise = ($urandom_range(3, 0) == 0);
         if (op[1]) rand_read(op, noise);
         else       run_bit(op, 16'h0000, noise, 1'b0);
         if ($urandom_range(4, 0) == 0) idle(int'($urandom_range(3, 1)));
      end
      idle(2);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule